// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits on a simple memory-mapped register bus and manages a small array of one-time-programmable fuse words. The array is modelled as ordinary storage whose bits can only go from 0 to 1. Software opens a programming window by loading a control register with a word address and a 16-bit unlock key. Writing a 32-bit value to the data register then starts a programming cycle. The controller holds a busy flag for a fixed number of clock cycles, then ORs the value into the selected word and wipes the key. The fuse words can be read back at any time through a word-per-4-byte window.

A data write is refused and the error flag is raised if the key is wrong, if the read bank is still enabled, or if a cycle is already running. A refused write leaves the array untouched. Set and clear aliases of the control register allow single fields to be changed without a read-modify-write. A synchronous reset returns all control state to zero and keeps the fuse contents.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After a synchronous reset the control register reads 0x0000_0000. Fuse words programmed before the reset read back unchanged after it.
- R2: A write to the control register at byte offset 0x00 loads the word address from bits 5:0, the read-bank enable from bit 12 and the key from bits 31:16. Bit 8 (busy) is read-only. Bits 7:6, 11:10 and 15:13 read 0. Writing 1 to bit 9 clears the error flag, and writing 0 there leaves it unchanged.
- R3: A write to the set alias at 0x04 ORs the written bits into the address, bank-enable and key fields. A write to the clear alias at 0x08 clears exactly those of the address, bank-enable, key and error bits that are 1 in the written value. Both aliases read back the control register.
- R4: A write to the data register at 0x10 starts a programming cycle when all of the following hold: the key field holds 0x3E77, bank-enable is 0, and busy is 0. Busy (bit 8) then reads 1 from the next cycle, for exactly PROG_CYCLES cycles.
- R5: When the cycle ends, the addressed word becomes its old value ORed with the data written. No operation ever turns a stored 1 back to 0.
- R6: The key field reads 0 once a programming cycle has ended.
- R7: A data write while the key field is not 0x3E77 sets the error flag (bit 9), does not raise busy, and leaves the array unchanged.
- R8: A data write while bank-enable is 1 sets the error flag and leaves the array unchanged.
- R9: A data write while busy sets the error flag. The running cycle still programs its original data.
- R10: Fuse word i reads at byte offset 0x20 + 4*i. Bus writes into that window have no effect. Reads of the data register, of unaligned addresses and of unmapped offsets return 0.
- R11: The word address and data are captured when a cycle starts. Changing the address field while busy does not redirect the programming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears control state only |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the presented address (0 when not selected) |

## Verification
The assertions check on every cycle the rules that can be seen one edge at a time:
- every refused data write raises the error flag;
- an accepted write raises busy without touching the error flag;
- busy lasts exactly PROG_CYCLES cycles, measured with a run counter in the checker;
- the key is zero when busy falls;
- a fuse word read on consecutive cycles never loses a 1.

Only the bench scenarios can show the values that reach the array:
- OR accumulation across several cycles;
- the captured address and data surviving a control rewrite while busy;
- window and alias decoding;
- fuse contents surviving reset.

The bench compares every read against its behavioural model.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    localparam int OFS_CTRL = 'h00;
    localparam int OFS_SET  = 'h04;
    localparam int OFS_CLR  = 'h08;
    localparam int OFS_DATA = 'h10;
    localparam int WIN_BASE = 'h20;

    localparam int WADDR_W  = 6;
    localparam int WORD_W   = 32;

    localparam int BIT_BUSY = 8;
    localparam int BIT_ERR  = 9;
    localparam int BIT_BANK = 12;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTRL,
        REG_SET,
        REG_CLR,
        REG_DATA,
        REG_FUSE
    } region_e;

endpackage

// File: rtl/otp_fuse_decode.sv
module otp_fuse_decode
    import otp_fuse_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int BUS_AW = 9
) (
    input  logic [BUS_AW-1:0]  addr,
    output region_e            region,
    output logic [WADDR_W-1:0] word
);
    localparam int IDX_W = BUS_AW - 2;

    logic [IDX_W-1:0] widx;
    logic             aligned;
    logic             in_win;

    always_comb begin
        widx    = addr[BUS_AW-1:2] - IDX_W'(WIN_BASE / 4);
        aligned = (addr[1:0] == 2'b00);
        in_win  = aligned && (addr >= BUS_AW'(WIN_BASE)) && (int'(widx) < WORDS);
        word    = widx[WADDR_W-1:0];

        if (addr == BUS_AW'(OFS_CTRL))      region = REG_CTRL;
        else if (addr == BUS_AW'(OFS_SET))  region = REG_SET;
        else if (addr == BUS_AW'(OFS_CLR))  region = REG_CLR;
        else if (addr == BUS_AW'(OFS_DATA)) region = REG_DATA;
        else if (in_win)                    region = REG_FUSE;
        else                                region = REG_NONE;
    end

endmodule

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank
    import otp_fuse_pkg::*;
#(
    parameter int WORDS = 64
) (
    input  logic               clk,
    input  logic               pgm_en,
    input  logic [WADDR_W-1:0] pgm_idx,
    input  logic [WORD_W-1:0]  pgm_bits,
    input  logic [WADDR_W-1:0] rd_idx,
    output logic [WORD_W-1:0]  rd_bits
);
    localparam int IW = $clog2(WORDS);

    logic [WORD_W-1:0] mem_q [WORDS] = '{default: '0};

    always_ff @(posedge clk) begin
        if (pgm_en) begin
            mem_q[pgm_idx[IW-1:0]] <= mem_q[pgm_idx[IW-1:0]] | pgm_bits;
        end
    end

    always_comb begin
        rd_bits = mem_q[rd_idx[IW-1:0]];
    end

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int PROG_CYCLES = 16,
    parameter int BUS_AW      = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

    typedef struct packed {
        logic [15:0]        key;
        logic               bank;
        logic               err;
        logic               busy;
        logic [WADDR_W-1:0] addr;
        logic [CNT_W-1:0]   cnt;
        logic [WADDR_W-1:0] op_addr;
        logic [WORD_W-1:0]  op_data;
    } ctl_t;

    localparam ctl_t CTL_RESET = '0;

    ctl_t               ctl_d, ctl_q;
    region_e            region;
    logic [WADDR_W-1:0] fuse_word;
    logic [WORD_W-1:0]  fuse_bits;
    logic [31:0]        ctrl_word;
    logic               commit;
    logic               start_ok;
    logic               wr_cycle;

    otp_fuse_decode #(
        .WORDS  (WORDS),
        .BUS_AW (BUS_AW)
    ) u_decode (
        .addr   (bus_addr),
        .region (region),
        .word   (fuse_word)
    );

    otp_fuse_bank #(
        .WORDS (WORDS)
    ) u_bank (
        .clk      (clk),
        .pgm_en   (commit),
        .pgm_idx  (ctl_q.op_addr),
        .pgm_bits (ctl_q.op_data),
        .rd_idx   (fuse_word),
        .rd_bits  (fuse_bits)
    );

    always_comb begin
        ctrl_word = {ctl_q.key, 3'b000, ctl_q.bank, 2'b00, ctl_q.err,
                     ctl_q.busy, 2'b00, ctl_q.addr};
    end

    always_comb begin
        ctl_d    = ctl_q;
        commit   = 1'b0;
        wr_cycle = bus_sel && bus_wr;
        start_ok = !ctl_q.busy && (ctl_q.key == UNLOCK_KEY) && !ctl_q.bank
                   && (int'(ctl_q.addr) < WORDS);

        if (wr_cycle) begin
            unique case (region)
                REG_CTRL: begin
                    ctl_d.addr = bus_wdata[WADDR_W-1:0];
                    ctl_d.bank = bus_wdata[BIT_BANK];
                    ctl_d.key  = bus_wdata[31:16];
                    if (bus_wdata[BIT_ERR]) ctl_d.err = 1'b0;
                end
                REG_SET: begin
                    ctl_d.addr = ctl_q.addr | bus_wdata[WADDR_W-1:0];
                    ctl_d.bank = ctl_q.bank | bus_wdata[BIT_BANK];
                    ctl_d.key  = ctl_q.key  | bus_wdata[31:16];
                end
                REG_CLR: begin
                    ctl_d.addr = ctl_q.addr & ~bus_wdata[WADDR_W-1:0];
                    ctl_d.bank = ctl_q.bank & ~bus_wdata[BIT_BANK];
                    ctl_d.key  = ctl_q.key  & ~bus_wdata[31:16];
                    if (bus_wdata[BIT_ERR]) ctl_d.err = 1'b0;
                end
                REG_DATA: begin
                    if (start_ok) begin
                        ctl_d.busy    = 1'b1;
                        ctl_d.cnt     = CNT_LAST;
                        ctl_d.op_addr = ctl_q.addr;
                        ctl_d.op_data = bus_wdata;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end

        if (ctl_q.busy) begin
            if (ctl_q.cnt == '0) begin
                commit     = 1'b1;
                ctl_d.busy = 1'b0;
                ctl_d.key  = '0;
            end else begin
                ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (region)
                REG_CTRL, REG_SET, REG_CLR: bus_rdata = ctrl_word;
                REG_FUSE:                   bus_rdata = fuse_bits;
                default:                    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
    import otp_fuse_pkg::*;
#(
    parameter int PROG_CYCLES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [31:0]        bus_rdata,
    input logic [31:0]        ctrl_word,
    input region_e            region,
    input logic [WADDR_W-1:0] fuse_word
);
    logic wr_data;
    logic rd_fuse;
    logic busy;
    logic err;
    int   busy_run;

    assign wr_data = bus_sel && bus_wr && (region == REG_DATA);
    assign rd_fuse = bus_sel && (region == REG_FUSE);
    assign busy    = ctrl_word[BIT_BUSY];
    assign err     = ctrl_word[BIT_ERR];

    always_ff @(posedge clk) begin
        if (rst) busy_run <= 0;
        else     busy_run <= busy ? busy_run + 1 : 0;
    end

    // R4: an accepted data write raises busy and leaves the error flag alone
    a_r4_start: assert property (@(posedge clk) disable iff (rst)
        (wr_data && ctrl_word[31:16] == UNLOCK_KEY && !ctrl_word[BIT_BANK] && !busy)
        |=> (busy && err == $past(err)));

    // R4: busy never lasts longer than PROG_CYCLES
    a_r4_busy_max: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < PROG_CYCLES));

    // R4: busy falls after exactly PROG_CYCLES cycles
    a_r4_busy_exact: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == PROG_CYCLES));

    // R4: busy only rises from a data write
    a_r4_busy_source: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_data));

    // R5: a fuse word seen on consecutive cycles never loses a set bit
    a_r5_monotonic: assert property (@(posedge clk) disable iff (rst)
        (rd_fuse && $past(rd_fuse) && fuse_word == $past(fuse_word))
        |-> (($past(bus_rdata) & ~bus_rdata) == 32'h0));

    // R6: key field is zero when the cycle ends
    a_r6_key_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (ctrl_word[31:16] == 16'h0));

    // R7: wrong key raises the error flag
    a_r7_bad_key: assert property (@(posedge clk) disable iff (rst)
        (wr_data && ctrl_word[31:16] != UNLOCK_KEY) |=> err);

    // R8: open read bank raises the error flag
    a_r8_bank_open: assert property (@(posedge clk) disable iff (rst)
        (wr_data && ctrl_word[BIT_BANK]) |=> err);

    // R9: data write while busy raises the error flag
    a_r9_busy_reject: assert property (@(posedge clk) disable iff (rst)
        (wr_data && busy) |=> err);

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .ctrl_word (ctrl_word),
    .region    (region),
    .fuse_word (fuse_word)
);

// File: tb/otp_fuse_ctrl_tb_top.sv
module otp_fuse_ctrl_tb_top;
    localparam int WORDS = 64;
    localparam int PCYC  = 16;
    localparam int AW    = 9;
    localparam logic [15:0] KEY = 16'h3E77;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    always #5 clk = ~clk;

    otp_fuse_ctrl #(
        .WORDS       (WORDS),
        .PROG_CYCLES (PCYC),
        .BUS_AW      (AW)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference model
    logic [31:0] m_fuse [WORDS];
    logic [5:0]  m_addr;
    logic [15:0] m_key;
    logic        m_bank, m_err, m_busy, m_was_busy;
    int          m_cnt, m_opa, m_a;
    logic [31:0] m_opd;

    function automatic logic [31:0] m_read(int a);
        if (a == 0 || a == 4 || a == 8)
            return {m_key, 3'b000, m_bank, 2'b00, m_err, m_busy, 2'b00, m_addr};
        if (a >= 32 && a < 32 + 4 * WORDS && (a % 4) == 0)
            return m_fuse[(a - 32) / 4];
        return 32'h0;
    endfunction

    initial begin
        for (int i = 0; i < WORDS; i++) m_fuse[i] = 32'h0;
        m_addr = 0; m_key = 0; m_bank = 0; m_err = 0; m_busy = 0;
        m_cnt = 0; m_opa = 0; m_opd = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_addr = 0; m_key = 0; m_bank = 0; m_err = 0; m_busy = 0; m_cnt = 0;
        end else begin
            m_was_busy = m_busy;
            if (bus_sel && bus_wr) begin
                m_a = int'(bus_addr);
                if (m_a == 0) begin
                    m_addr = bus_wdata[5:0]; m_bank = bus_wdata[12]; m_key = bus_wdata[31:16];
                    if (bus_wdata[9]) m_err = 0;
                end else if (m_a == 4) begin
                    m_addr |= bus_wdata[5:0]; m_bank |= bus_wdata[12]; m_key |= bus_wdata[31:16];
                end else if (m_a == 8) begin
                    m_addr &= ~bus_wdata[5:0]; m_bank &= ~bus_wdata[12]; m_key &= ~bus_wdata[31:16];
                    if (bus_wdata[9]) m_err = 0;
                end else if (m_a == 16) begin
                    if (m_was_busy || m_key != KEY || m_bank) m_err = 1;
                    else begin
                        m_busy = 1; m_cnt = PCYC; m_opa = int'(m_addr); m_opd = bus_wdata;
                    end
                end
            end
            if (m_was_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_fuse[m_opa] = m_fuse[m_opa] | m_opd;
                    m_busy = 0;
                    m_key = 0;
                end
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // one bus cycle; every read is compared against the model
    task automatic cyc(input logic s, input logic w, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        if (s) check(bus_rdata, m_read(int'(a)), "model");
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d);
    endtask

    task automatic rd_expect(input logic [AW-1:0] a, input logic [31:0] exp, input string what);
        cyc(1'b1, 1'b0, a, 32'h0);
        check(bus_rdata, exp, what);
    endtask

    task automatic wait_prog(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            cyc(1'b1, 1'b0, '0, 32'h0);
            if (bus_rdata[8]) n++;
            else break;
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int n;
        rst = 1'b1;
        cyc(1'b0, 1'b0, '0, 32'h0);
        cyc(1'b0, 1'b0, '0, 32'h0);
        @(negedge clk); rst = 1'b0;

        cur_req = "R1";
        rd_expect(9'h000, 32'h0000_0000, "r1_ctrl_after_reset");
        rd_expect(9'h020, 32'h0000_0000, "r1_word0_blank");

        cur_req = "R2";
        wr(9'h000, 32'h1234_1205);
        rd_expect(9'h000, 32'h1234_1005, "r2_fields_loaded");
        wr(9'h000, 32'h1234_1105);
        rd_expect(9'h000, 32'h1234_1005, "r2_busy_read_only");

        cur_req = "R3";
        wr(9'h008, 32'h0000_1000);
        rd_expect(9'h004, 32'h1234_0005, "r3_clear_bank");
        wr(9'h004, 32'h0000_0002);
        rd_expect(9'h008, 32'h1234_0007, "r3_set_addr");

        cur_req = "R7";
        wr(9'h000, 32'h1234_0003);
        wr(9'h010, 32'h0000_00FF);
        rd_expect(9'h000, 32'h1234_0203, "r7_error_no_busy");
        rd_expect(9'h02C, 32'h0000_0000, "r7_word3_untouched");

        cur_req = "R2";
        wr(9'h000, 32'h0000_0200);
        rd_expect(9'h000, 32'h0000_0000, "r2_error_cleared");

        cur_req = "R8";
        wr(9'h000, 32'h3E77_1003);
        wr(9'h010, 32'h0000_00F0);
        rd_expect(9'h000, 32'h3E77_1203, "r8_error_bank_open");
        rd_expect(9'h02C, 32'h0000_0000, "r8_word3_untouched");
        cur_req = "R3";
        wr(9'h008, 32'h0000_1200);
        rd_expect(9'h000, 32'h3E77_0003, "r3_clear_err_and_bank");

        cur_req = "R4";
        wr(9'h010, 32'h0000_00F0);
        wait_prog(n);
        check(32'(n), 32'(PCYC), "r4_busy_length");
        cur_req = "R5";
        rd_expect(9'h02C, 32'h0000_00F0, "r5_word3_programmed");
        cur_req = "R6";
        rd_expect(9'h000, 32'h0000_0003, "r6_key_wiped");

        cur_req = "R5";
        wr(9'h000, 32'h3E77_0003);
        wr(9'h010, 32'h0000_000F);
        wait_prog(n);
        rd_expect(9'h02C, 32'h0000_00FF, "r5_or_accumulate");
        wr(9'h000, 32'h3E77_0003);
        wr(9'h010, 32'h0000_0000);
        wait_prog(n);
        rd_expect(9'h02C, 32'h0000_00FF, "r5_zero_write_keeps_ones");

        cur_req = "R9";
        wr(9'h000, 32'h3E77_0021);
        wr(9'h010, 32'hA5A5_0000);
        wr(9'h010, 32'h0000_5A5A);
        cur_req = "R11";
        wr(9'h000, 32'h3E77_0022);
        wait_prog(n);
        check(32'(n), 32'(PCYC - 2), "r11_remaining_busy");
        cur_req = "R9";
        rd_expect(9'h000, 32'h0000_0222, "r9_error_flag_set");
        rd_expect(9'h0A4, 32'hA5A5_0000, "r9_original_data");
        cur_req = "R11";
        rd_expect(9'h0A8, 32'h0000_0000, "r11_not_redirected");

        cur_req = "R10";
        wr(9'h0A4, 32'hFFFF_FFFF);
        rd_expect(9'h0A4, 32'hA5A5_0000, "r10_window_write_ignored");
        rd_expect(9'h01C, 32'h0000_0000, "r10_unmapped_low");
        rd_expect(9'h010, 32'h0000_0000, "r10_data_reads_zero");
        rd_expect(9'h0A6, 32'h0000_0000, "r10_unaligned");
        wr(9'h000, 32'h3E77_023F);
        wr(9'h010, 32'h8000_0001);
        wait_prog(n);
        rd_expect(9'h11C, 32'h8000_0001, "r10_last_word");
        rd_expect(9'h120, 32'h0000_0000, "r10_past_window");

        cur_req = "R1";
        @(negedge clk); rst = 1'b1;
        cyc(1'b0, 1'b0, '0, 32'h0);
        @(negedge clk); rst = 1'b0;
        rd_expect(9'h000, 32'h0000_0000, "r1_ctrl_cleared");
        rd_expect(9'h0A4, 32'hA5A5_0000, "r1_fuse_kept");
        rd_expect(9'h02C, 32'h0000_00FF, "r1_fuse3_kept");

        cyc(1'b0, 1'b0, '0, 32'h0);
        summary();
    end

endmodule